// File: doc/BRIEF.md
# Dual-Group Touch Switch Closure Qualifier

This block sits behind a maintenance panel that has two groups of touch switches, one for addresses and one for data. Each group reports a single active-high "a switch in this group is closed" level. The block turns those levels into clean, single events. A closure must stay qualified for a full detection window. It then yields one accept strobe, tagged with the group that produced it. After that the block stays busy until the panel has been quiet for a lockout window. A switch that is held down therefore produces exactly one event.

The two groups lock each other out: a closure is only taken from a group while the other group's level is low. Closures are examined only while two inhibit inputs are low, an active-low select input is high and a set-up inhibit is low. A monitor watches a periodic reference tick. If the tick goes missing, the monitor forces the block back to idle and blocks new detection. All delays are cycle counters on the free-running system clock.

Top module: `touch_closure_qualifier`

## Requirements
- R1: While reset is applied and after it is released, `accept_o` and `accept_is_data_o` are low. After reset the tick monitor is cleared, so a held closure is not accepted until a reference tick has arrived.
- R2: A closure is examined only when `inhibit0_i` and `inhibit1_i` are low, `sel_n_i` is high and `setup_inh_i` is low. If any of these gates is closed, a held closure gives no accept.
- R3: The address group qualifies only while `data_closed_i` is low, and the data group only while `addr_closed_i` is low. If both are high, nothing is accepted. If the other group rises during detection, the detection is abandoned.
- R4: The first edge that samples a qualified closure starts detection. `accept_o` is high in the cycle after the DETECT_CYC-th following edge, which is DETECT_CYC+1 edges counting the first. If the closure leaves qualification earlier, detection is abandoned and no accept is given.
- R5: `accept_o` is a one-cycle strobe. `accept_is_data_o` is 1 with the strobe for a data-group closure and 0 for an address-group closure, and it is low whenever `accept_o` is low.
- R6: After an accept, the block is busy. While the qualified closure stays present, no further accept occurs.
- R7: The block re-arms only after LOCKOUT_CYC consecutive edges that sample no qualified closure. A new closure sampled before that restarts the quiet window and is not accepted.
- R8: While `setup_inh_i` is high, any detection in progress is cleared. After it falls, a still-held closure needs a full new detection window.
- R9: If no `ref_tick_i` pulse has arrived for MON_CYC cycles, the busy state is cleared and no detection starts until ticks return.
- R10: Asserting `rst_n_i` during the busy state clears it. A closure held through reset is accepted once again after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_n_i | input | 1 | Master reset, active low, asynchronous assert |
| ref_tick_i | input | 1 | Periodic reference tick for the clock-presence monitor |
| addr_closed_i | input | 1 | Some address-group switch is closed |
| data_closed_i | input | 1 | Some data-group switch is closed |
| inhibit0_i | input | 1 | First closure inhibit, active high |
| inhibit1_i | input | 1 | Second closure inhibit, active high |
| sel_n_i | input | 1 | Select, active low; must be high to examine closures |
| setup_inh_i | input | 1 | Global inhibit while panel logic is being set up |
| accept_o | output | 1 | One-cycle accept strobe |
| accept_is_data_o | output | 1 | Group tag of the strobe: 1 data, 0 address |

## Verification
Several properties are checked on every cycle: that the strobe lasts a single cycle and its tag never appears alone, and that every accept traces back to inputs that were gated open and mutually exclusive one edge earlier. They also check that a held closure keeps the block busy, and that the set-up inhibit and a missing tick return the sequencer to idle or busy at once. The exact lengths of the detection and quiet windows cannot be seen by these per-cycle checks. Nor can the abandonment of a short press, or the re-acceptance after reset or tick loss. Only the bench's timed scenarios, which count edges from each stimulus, show those.

// File: rtl/tcq_pkg.sv
`timescale 1ns/1ps
package tcq_pkg;

  localparam int unsigned NUM_GROUPS = 2;
  localparam int unsigned GRP_W      = $clog2(NUM_GROUPS);
  localparam int unsigned GRP_ADDR   = 0;
  localparam int unsigned GRP_DATA   = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DETECT = 2'd1,
    ST_PULSE  = 2'd2,
    ST_BUSY   = 2'd3
  } tcq_state_e;

endpackage

// File: rtl/tcq_clk_monitor.sv
`timescale 1ns/1ps
module tcq_clk_monitor #(
  parameter int unsigned MON_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic alive
);

  localparam int unsigned CW = $clog2(MON_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MON_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = tick | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (tick) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign alive = (cnt_q != '0);

endmodule

// File: rtl/tcq_qualify.sv
`timescale 1ns/1ps
module tcq_qualify #(
  parameter int unsigned NG = tcq_pkg::NUM_GROUPS
) (
  input  logic [NG-1:0] closed,
  input  logic          inhibit0,
  input  logic          inhibit1,
  input  logic          sel_n,
  input  logic          setup_inh,
  input  logic          clk_alive,
  output logic [NG-1:0] grp_ok,
  output logic          any_ok
);

  logic gates_open;

  assign gates_open = ~inhibit0 & ~inhibit1 & sel_n & ~setup_inh & clk_alive;

  // A group qualifies only when no other group reports a closure.
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [NG-1:0] self_mask;
    assign self_mask = {{(NG-1){1'b0}}, 1'b1} << g;
    assign grp_ok[g] = gates_open & closed[g] & ~|(closed & ~self_mask);
  end

  assign any_ok = gates_open & (|closed);

endmodule

// File: rtl/tcq_sequencer.sv
`timescale 1ns/1ps
module tcq_sequencer
  import tcq_pkg::*;
#(
  parameter int unsigned NG          = NUM_GROUPS,
  parameter int unsigned DETECT_CYC  = 475000,
  parameter int unsigned PULSE_CYC   = 25,
  parameter int unsigned LOCKOUT_CYC = 6000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NG-1:0]       grp_ok,
  input  logic                any_ok,
  input  logic                clk_alive,
  input  logic                setup_inh,
  output logic                accept,
  output logic [GRP_W-1:0]    accept_grp,
  output tcq_state_e          state
);

  localparam int unsigned MAX_A  = (DETECT_CYC > PULSE_CYC) ? DETECT_CYC : PULSE_CYC;
  localparam int unsigned MAX_CY = (MAX_A > LOCKOUT_CYC) ? MAX_A : LOCKOUT_CYC;
  localparam int unsigned CW     = $clog2(MAX_CY + 1);
  localparam logic [CW-1:0] DET_LOAD  = CW'(DETECT_CYC - 1);
  localparam logic [CW-1:0] PUL_LOAD  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] LOCK_LOAD = CW'(LOCKOUT_CYC - 1);

  tcq_state_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [GRP_W-1:0]  grp_q, grp_d, grp_pick;
  logic              pick_any;
  logic              acc_q, acc_d;
  logic              seq_en;

  // Lowest-numbered qualifying group; groups are exclusive by construction.
  always_comb begin
    grp_pick = '0;
    pick_any = 1'b0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_ok[g]) begin
        grp_pick = GRP_W'(g);
        pick_any = 1'b1;
      end
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    grp_d = grp_q;
    acc_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pick_any) begin
          st_d  = ST_DETECT;
          grp_d = grp_pick;
          cnt_d = DET_LOAD;
        end
      end
      ST_DETECT: begin
        if (!grp_ok[grp_q]) begin
          st_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          st_d  = ST_PULSE;
          cnt_d = PUL_LOAD;
          acc_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PULSE: begin
        if (!clk_alive || setup_inh) begin
          st_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          st_d  = ST_BUSY;
          cnt_d = LOCK_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_BUSY: begin
        if (!clk_alive) begin
          st_d = ST_IDLE;
        end else if (any_ok) begin
          cnt_d = LOCK_LOAD;
        end else if (cnt_q == '0) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign seq_en = (st_q != ST_IDLE) | pick_any | acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      grp_q <= '0;
      acc_q <= 1'b0;
    end else if (seq_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      grp_q <= grp_d;
      acc_q <= acc_d;
    end
  end

  assign accept     = acc_q;
  assign accept_grp = grp_q;
  assign state      = st_q;

endmodule

// File: rtl/touch_closure_qualifier.sv
`timescale 1ns/1ps
module touch_closure_qualifier
  import tcq_pkg::*;
#(
  parameter int unsigned DETECT_CYC  = 475000,
  parameter int unsigned PULSE_CYC   = 25,
  parameter int unsigned LOCKOUT_CYC = 6000000,
  parameter int unsigned MON_CYC     = 250
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ref_tick_i,
  input  logic addr_closed_i,
  input  logic data_closed_i,
  input  logic inhibit0_i,
  input  logic inhibit1_i,
  input  logic sel_n_i,
  input  logic setup_inh_i,
  output logic accept_o,
  output logic accept_is_data_o
);

  logic                   rst_meta_n, rst_sync_n;
  logic [NUM_GROUPS-1:0]  closed_vec;
  logic [NUM_GROUPS-1:0]  grp_ok;
  logic                   any_ok;
  logic                   clk_alive;
  logic                   seq_accept;
  logic [GRP_W-1:0]       seq_grp;
  tcq_state_e             seq_state;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    closed_vec           = '0;
    closed_vec[GRP_ADDR] = addr_closed_i;
    closed_vec[GRP_DATA] = data_closed_i;
  end

  tcq_clk_monitor #(
    .MON_CYC (MON_CYC)
  ) i_mon (
    .clk   (clk_i),
    .rst_n (rst_sync_n),
    .tick  (ref_tick_i),
    .alive (clk_alive)
  );

  tcq_qualify #(
    .NG (NUM_GROUPS)
  ) i_qual (
    .closed    (closed_vec),
    .inhibit0  (inhibit0_i),
    .inhibit1  (inhibit1_i),
    .sel_n     (sel_n_i),
    .setup_inh (setup_inh_i),
    .clk_alive (clk_alive),
    .grp_ok    (grp_ok),
    .any_ok    (any_ok)
  );

  tcq_sequencer #(
    .NG          (NUM_GROUPS),
    .DETECT_CYC  (DETECT_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .LOCKOUT_CYC (LOCKOUT_CYC)
  ) i_seq (
    .clk        (clk_i),
    .rst_n      (rst_sync_n),
    .grp_ok     (grp_ok),
    .any_ok     (any_ok),
    .clk_alive  (clk_alive),
    .setup_inh  (setup_inh_i),
    .accept     (seq_accept),
    .accept_grp (seq_grp),
    .state      (seq_state)
  );

  assign accept_o         = seq_accept;
  assign accept_is_data_o = seq_accept & (seq_grp == GRP_W'(GRP_DATA));

endmodule

// File: rtl/tcq_checker.sv
`timescale 1ns/1ps
module tcq_checker
  import tcq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       addr_closed,
  input logic       data_closed,
  input logic       inhibit0,
  input logic       inhibit1,
  input logic       sel_n,
  input logic       setup_inh,
  input logic       accept,
  input logic       accept_data,
  input logic       clk_alive,
  input logic       any_ok,
  input tcq_state_e state
);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  assert_tag_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_data |-> accept);

  assert_addr_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !accept_data) |-> $past(addr_closed && !data_closed));

  assert_data_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_data) |-> $past(data_closed && !addr_closed));

  assert_gates_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(!inhibit0 && !inhibit1 && sel_n && !setup_inh));

  assert_from_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> $past(state == ST_DETECT));

  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && any_ok && clk_alive) |=> (state == ST_BUSY));

  assert_setup_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    setup_inh |=> (state == ST_IDLE || state == ST_BUSY));

  assert_monitor_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_alive |=> (state == ST_IDLE));

endmodule

bind touch_closure_qualifier tcq_checker i_tcq_checker (
  .clk         (clk_i),
  .rst_n       (rst_sync_n),
  .addr_closed (addr_closed_i),
  .data_closed (data_closed_i),
  .inhibit0    (inhibit0_i),
  .inhibit1    (inhibit1_i),
  .sel_n       (sel_n_i),
  .setup_inh   (setup_inh_i),
  .accept      (accept_o),
  .accept_data (accept_is_data_o),
  .clk_alive   (clk_alive),
  .any_ok      (any_ok),
  .state       (seq_state)
);

// File: tb/test_touch_closure_qualifier.sv
`timescale 1ns/1ps
module test_touch_closure_qualifier;

  localparam int DET  = 20;
  localparam int PUL  = 3;
  localparam int LOCK = 40;
  localparam int MON  = 8;

  logic clk = 1'b0;
  logic rst_n, ref_tick, addr_c, data_c, inh0, inh1, sel_n, setup;
  logic accept, acc_data;
  logic tick_run;
  int   tick_div;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #2 clk = ~clk;

  touch_closure_qualifier #(
    .DETECT_CYC  (DET),
    .PULSE_CYC   (PUL),
    .LOCKOUT_CYC (LOCK),
    .MON_CYC     (MON)
  ) i_touch_closure_qualifier (
    .clk_i            (clk),
    .rst_n_i          (rst_n),
    .ref_tick_i       (ref_tick),
    .addr_closed_i    (addr_c),
    .data_closed_i    (data_c),
    .inhibit0_i       (inh0),
    .inhibit1_i       (inh1),
    .sel_n_i          (sel_n),
    .setup_inh_i      (setup),
    .accept_o         (accept),
    .accept_is_data_o (acc_data)
  );

  always @(negedge clk) begin
    if (tick_run) begin
      tick_div = (tick_div + 1) % 4;
      ref_tick = (tick_div == 0);
    end else begin
      ref_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Edges from now until the strobe is seen; -1 if not within maxc.
  task automatic to_accept(input int maxc, output int n);
    n = -1;
    for (int k = 1; k <= maxc; k++) begin
      @(negedge clk);
      if (accept) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic count_acc(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (accept) c++;
    end
  endtask

  task automatic settle();
    addr_c = 1'b0;
    data_c = 1'b0;
    cycles(LOCK + DET + 10);
  endtask

  task automatic t_reset();
    int c;
    rst_n = 1'b0; ref_tick = 1'b0; addr_c = 1'b0; data_c = 1'b0;
    inh0 = 1'b0; inh1 = 1'b0; sel_n = 1'b1; setup = 1'b0;
    tick_run = 1'b0; tick_div = 0;
    cycles(5);
    check(accept == 1'b0 && acc_data == 1'b0, "R1 outputs in reset", accept, 0);
    rst_n = 1'b1;
    cycles(3);
    check(accept == 1'b0, "R1 outputs after reset", accept, 0);
    addr_c = 1'b1;
    count_acc(3 * DET, c);
    check(c == 0, "R1 no accept before first tick", c, 0);
    addr_c = 1'b0;
    tick_run = 1'b1;
    cycles(LOCK + 10);
  endtask

  task automatic t_addr_timing();
    int n, c;
    addr_c = 1'b1;
    to_accept(DET + 10, n);
    check(n == DET + 1, "R4 detect window length", n, DET + 1);
    check(acc_data == 1'b0, "R5 address tag", acc_data, 0);
    cycles(1);
    check(accept == 1'b0, "R5 strobe lasts one cycle", accept, 0);
    count_acc(3 * LOCK, c);
    check(c == 0, "R6 held closure gives no second accept", c, 0);
    settle();
  endtask

  task automatic t_data_group();
    int n;
    data_c = 1'b1;
    to_accept(DET + 10, n);
    check(n == DET + 1, "R4 data detect window", n, DET + 1);
    check(acc_data == 1'b1, "R5 data tag", acc_data, 1);
    settle();
  endtask

  task automatic t_abort();
    int c;
    addr_c = 1'b1;
    cycles(DET / 2);
    addr_c = 1'b0;
    count_acc(3 * DET, c);
    check(c == 0, "R4 short press abandoned", c, 0);
    settle();
  endtask

  task automatic t_gates();
    int c;
    for (int g = 0; g < 3; g++) begin
      inh0  = (g == 0);
      inh1  = (g == 1);
      sel_n = (g != 2);
      addr_c = 1'b1;
      count_acc(2 * DET, c);
      check(c == 0, "R2 closed gate blocks closure", c, 0);
      addr_c = 1'b0;
      inh0 = 1'b0; inh1 = 1'b0; sel_n = 1'b1;
      cycles(5);
    end
  endtask

  task automatic t_mutex();
    int n, c;
    addr_c = 1'b1;
    data_c = 1'b1;
    count_acc(2 * DET, c);
    check(c == 0, "R3 both groups closed", c, 0);
    data_c = 1'b0;
    to_accept(DET + 10, n);
    check(n == DET + 1, "R3 address after data release", n, DET + 1);
    check(acc_data == 1'b0, "R3 address tag", acc_data, 0);
    settle();
    addr_c = 1'b1;
    cycles(DET / 2);
    data_c = 1'b1;
    count_acc(3 * DET, c);
    check(c == 0, "R3 other group aborts detection", c, 0);
    settle();
  endtask

  task automatic t_lockout();
    int n, c;
    addr_c = 1'b1;
    to_accept(DET + 10, n);
    cycles(10);
    addr_c = 1'b0;
    cycles(LOCK);
    addr_c = 1'b1;
    to_accept(DET + 10, n);
    check(n == DET + 1, "R7 accepted after full quiet window", n, DET + 1);
    cycles(10);
    addr_c = 1'b0;
    cycles(LOCK - 1);
    addr_c = 1'b1;
    count_acc(3 * DET + LOCK, c);
    check(c == 0, "R7 early re-press not accepted", c, 0);
    settle();
  endtask

  task automatic t_setup();
    int n, c;
    addr_c = 1'b1;
    cycles(DET / 2);
    setup = 1'b1;
    count_acc(2 * DET, c);
    check(c == 0, "R8 set-up inhibit blocks", c, 0);
    setup = 1'b0;
    to_accept(DET + 10, n);
    check(n == DET + 1, "R8 full new window after inhibit", n, DET + 1);
    settle();
  endtask

  task automatic t_monitor();
    int n, c;
    addr_c = 1'b1;
    to_accept(DET + 10, n);
    cycles(10);
    tick_run = 1'b0;
    count_acc(30, c);
    check(c == 0, "R9 no detection without ticks", c, 0);
    tick_run = 1'b1;
    to_accept(DET + 20, n);
    check(n > 0 && n <= DET + 6, "R9 busy cleared by missing ticks", n, DET + 1);
    settle();
  endtask

  task automatic t_reset_mid();
    int n;
    addr_c = 1'b1;
    to_accept(DET + 10, n);
    cycles(10);
    rst_n = 1'b0;
    cycles(3);
    check(accept == 1'b0, "R10 output low in reset", accept, 0);
    rst_n = 1'b1;
    to_accept(DET + 30, n);
    check(n > 0, "R10 held closure accepted after reset", n, DET + 1);
    settle();
  endtask

  initial begin
    t_reset();
    t_addr_timing();
    t_data_group();
    t_abort();
    t_gates();
    t_mutex();
    t_lockout();
    t_setup();
    t_monitor();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule